// File: doc/BRIEF.md
# DMA Programming Interface and Command Decoder

This block is the processor-facing side of a four-channel DMA controller. It watches chip select, read and write strobes, bus-grant acknowledge and a four-bit register address. When the processor owns the bus it turns each strobe into exactly one register access. Channel address and count registers are 16 bits wide but are reached one byte at a time. A byte pointer flip-flop supplies the missing address bit. The block drives one-hot read and write enables, plus a high-byte select, for those registers, which live in the channel datapath. Several addresses carry commands that use no data: pointer set and clear, master clear, mask clear and mode-readback restart.

The block owns the request mask, and in 16-bit mode a per-channel transfer-width register. Both sit behind a single address. On a write to that address, one data bit decides which of the two is updated. The command byte and the per-channel mode fields are stored and exported unchanged. Read data is registered when the read strobe is first seen.

Address map, with a = addr[3:0] and ch = a[2:1] in the channel region: a[3]=0 is a channel register (a[0]=0 for current address, 1 for count). 8 command byte, 9 mode, 10 mask/width, 11 all-mask write, 12 pointer clear (write) or readback restart (read), 13 pointer set, 14 master clear, 15 mask clear.

Top module: `dmaprog_regif`

## Requirements
- R1: An access takes place only while cs_n=0 and hlda=0. Otherwise the strobes change no state, raise no enable and leave dout unchanged.
- R2: One low period of a strobe is one access. The access is taken in the first cycle the strobe is sampled low, and later cycles of the same low period do nothing.
- R3: In that first cycle, an address with a[3]=0 raises exactly one enable for channel a[2:1]: addr_we/addr_re when a[0]=0, cnt_we/cnt_re when a[0]=1. byte_hi gives the pointer value (0 = low byte).
- R4: The pointer toggles after every channel-register byte access, read or write.
- R5: A write to 12 clears the pointer and a write to 13 sets it. The data bus is ignored.
- R6: A write to 14 (master clear) sets all mask bits and all width bits. It clears the pointer, the command byte and the mode-readback index, and keeps the mode fields.
- R7: Reset gives the state of R6, with all mode fields 0 and dout 0.
- R8: With wide_en=1, a write to 10 with d[3]=0 loads width bits 0..3 from d[4..7] (0 = 16-bit, 1 = 8-bit) and leaves the mask unchanged.
- R9: A write to 10 with d[3]=1, or any write to 10 with wide_en=0, sets (d[2]=1) or clears (d[2]=0) the mask bit of channel d[1:0]. d[7:4] and the width bits are left unchanged.
- R10: A write to 11 loads the mask from d[3:0] and a write to 15 clears all mask bits. Neither changes the width bits.
- R11: A read of 10 returns the mask in d[3:0], and in d[7:4] the width bits if wide_en=1 or 1111 if wide_en=0. Reads of channel registers and of 8, 11, 13, 14, 15 return 0.
- R12: A write to 8 stores the command byte. A write to 9 stores d[7:2] as the mode field of channel d[1:0].
- R13: Each read of 9 returns {mode field, index} for the channel given by a readback index, then advances the index modulo 4. A read of 12 returns 0 and resets the index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ior_n | input | 1 | Read strobe, active low |
| iow_n | input | 1 | Write strobe, active low |
| hlda | input | 1 | Bus granted to DMA; blocks programming when high |
| addr | input | 4 | Register address |
| din | input | 8 | Write data |
| wide_en | input | 1 | 16-bit transfer mode enable |
| dout | output | 8 | Registered read data |
| byte_hi | output | 1 | Byte pointer: 1 selects the upper byte |
| addr_we | output | 4 | Per-channel current-address byte write enable |
| cnt_we | output | 4 | Per-channel count byte write enable |
| addr_re | output | 4 | Per-channel current-address byte read enable |
| cnt_re | output | 4 | Per-channel count byte read enable |
| mask_o | output | 4 | Request mask, 1 = masked |
| width_o | output | 4 | Width bits, 1 = 8-bit, 0 = 16-bit |
| cmd_o | output | 8 | Stored command byte |
| mode_o | output | 24 | Mode fields, channel c at bits [6c+5:6c] |

## Verification
Channel enables are combinational. They are due in the same cycle the strobe is first sampled low, so the bench samples them one nanosecond after driving that cycle's inputs. It samples again in the following cycle, where they must be low. Stored state and dout change at the first rising edge that sees the strobe low. The bench compares them only after the strobe has been held one more cycle and released. This also shows that the held cycle added nothing. Unqualified strobes are driven through the same sequence, and the bench expects every output to keep its previous value.

// File: rtl/dmaprog_pkg.sv
package dmaprog_pkg;

   // control-region operations, selected by addr[2:0] when addr msb is set
   typedef enum logic [2:0] {
      CTL_CMD     = 3'd0,
      CTL_MODE    = 3'd1,
      CTL_SHARED  = 3'd2,
      CTL_MASKALL = 3'd3,
      CTL_PTRCLR  = 3'd4,
      CTL_PTRSET  = 3'd5,
      CTL_MCLR    = 3'd6,
      CTL_MASKCLR = 3'd7
   } ctl_op_e;

endpackage

// File: rtl/dmaprog_strobe.sv
module dmaprog_strobe (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic hlda,
   input  logic ior_n,
   input  logic iow_n,
   output logic rd_pulse,
   output logic wr_pulse
);
   logic sel, rd_on, wr_on, rd_seen, wr_seen;

   assign sel   = !cs_n && !hlda;
   assign rd_on = sel && !ior_n && iow_n;
   assign wr_on = sel && !iow_n && ior_n;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rd_seen <= 1'b0;
         wr_seen <= 1'b0;
      end else begin
         rd_seen <= rd_on;
         wr_seen <= wr_on;
      end
   end

   assign rd_pulse = rd_on && !rd_seen;
   assign wr_pulse = wr_on && !wr_seen;
endmodule

// File: rtl/dmaprog_byteptr.sv
module dmaprog_byteptr (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic set,
   input  logic flip,
   output logic ptr
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)       ptr <= 1'b0;
      else if (clr)  ptr <= 1'b0;
      else if (set)  ptr <= 1'b1;
      else if (flip) ptr <= !ptr;
   end
endmodule

// File: rtl/dmaprog_maskwidth.sv
module dmaprog_maskwidth #(
   parameter int CH_BITS       = 2,
   parameter int NUM_CH        = 1 << CH_BITS,
   parameter int DATA_W        = 8,
   parameter bit WIDTH_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mclr,
   input  logic              wide_en,
   input  logic              shared_wr,
   input  logic              all_wr,
   input  logic              clr_all,
   input  logic [DATA_W-1:0] din,
   output logic [NUM_CH-1:0] mask,
   output logic [NUM_CH-1:0] width
);
   localparam int SET_BIT = CH_BITS;
   localparam int SEL_BIT = CH_BITS + 1;
   localparam int WID_LO  = NUM_CH;

   logic width_wr, single_wr;
   logic [CH_BITS-1:0] tgt;

   assign width_wr  = shared_wr && WIDTH_SUPPORT && wide_en && !din[SEL_BIT];
   assign single_wr = shared_wr && !width_wr;
   assign tgt       = din[CH_BITS-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
      always_ff @(posedge clk or posedge rst) begin
         if (rst)                                    mask[c] <= 1'b1;
         else if (mclr)                              mask[c] <= 1'b1;
         else if (clr_all)                           mask[c] <= 1'b0;
         else if (all_wr)                            mask[c] <= din[c];
         else if (single_wr && tgt == CH_BITS'(c))   mask[c] <= din[SET_BIT];
      end
   end

   if (WIDTH_SUPPORT) begin : g_width
      always_ff @(posedge clk or posedge rst) begin
         if (rst)           width <= '1;
         else if (mclr)     width <= '1;
         else if (width_wr) width <= din[WID_LO +: NUM_CH];
      end
   end else begin : g_no_width
      assign width = '1;
   end
endmodule

// File: rtl/dmaprog_progregs.sv
module dmaprog_progregs #(
   parameter int CH_BITS = 2,
   parameter int NUM_CH  = 1 << CH_BITS,
   parameter int DATA_W  = 8,
   parameter int MODE_W  = DATA_W - CH_BITS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     mclr,
   input  logic                     cmd_wr,
   input  logic                     mode_wr,
   input  logic                     mode_rd,
   input  logic                     idx_clr,
   input  logic [DATA_W-1:0]        din,
   output logic [DATA_W-1:0]        cmd,
   output logic [NUM_CH*MODE_W-1:0] modes,
   output logic [DATA_W-1:0]        mode_rd_val
);
   logic [MODE_W-1:0]  mode_r [NUM_CH];
   logic [CH_BITS-1:0] idx;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)         cmd <= '0;
      else if (mclr)   cmd <= '0;
      else if (cmd_wr) cmd <= din;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)                     idx <= '0;
      else if (mclr || idx_clr)    idx <= '0;
      else if (mode_rd)            idx <= idx + CH_BITS'(1);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
      always_ff @(posedge clk or posedge rst) begin
         if (rst)
            mode_r[c] <= '0;
         else if (mode_wr && din[CH_BITS-1:0] == CH_BITS'(c))
            mode_r[c] <= din[DATA_W-1:CH_BITS];
      end
      assign modes[c*MODE_W +: MODE_W] = mode_r[c];
   end

   assign mode_rd_val = {mode_r[idx], idx};
endmodule

// File: rtl/dmaprog_regif.sv
module dmaprog_regif #(
   parameter int CH_BITS       = 2,
   parameter int NUM_CH        = 1 << CH_BITS,
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = CH_BITS + 2,
   parameter int MODE_W        = DATA_W - CH_BITS,
   parameter bit WIDTH_SUPPORT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cs_n,
   input  logic                     ior_n,
   input  logic                     iow_n,
   input  logic                     hlda,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        din,
   input  logic                     wide_en,
   output logic [DATA_W-1:0]        dout,
   output logic                     byte_hi,
   output logic [NUM_CH-1:0]        addr_we,
   output logic [NUM_CH-1:0]        cnt_we,
   output logic [NUM_CH-1:0]        addr_re,
   output logic [NUM_CH-1:0]        cnt_re,
   output logic [NUM_CH-1:0]        mask_o,
   output logic [NUM_CH-1:0]        width_o,
   output logic [DATA_W-1:0]        cmd_o,
   output logic [NUM_CH*MODE_W-1:0] mode_o
);
   import dmaprog_pkg::*;

   localparam int NUM_OPS = 8;

   initial begin
      assert (CH_BITS >= 2) else $fatal(1, "CH_BITS must be at least 2");
      assert (NUM_CH == (1 << CH_BITS)) else $fatal(1, "NUM_CH must equal 2**CH_BITS");
      assert (ADDR_W == CH_BITS + 2) else $fatal(1, "ADDR_W must equal CH_BITS+2");
      assert (DATA_W >= 2 * NUM_CH) else $fatal(1, "DATA_W too small for mask and width");
      assert (MODE_W == DATA_W - CH_BITS) else $fatal(1, "MODE_W inconsistent");
   end

   logic               rd_p, wr_p, ctl_hit, is_cnt, chan_acc;
   logic [CH_BITS-1:0] chan;
   ctl_op_e            op;
   logic [NUM_OPS-1:0] op_wr, op_rd;
   logic [DATA_W-1:0]  mode_rd_val, shared_rd_val, rd_val;
   logic [NUM_CH-1:0]  width_rd;

   dmaprog_strobe u_strobe (
      .clk(clk), .rst(rst), .cs_n(cs_n), .hlda(hlda),
      .ior_n(ior_n), .iow_n(iow_n), .rd_pulse(rd_p), .wr_pulse(wr_p)
   );

   assign ctl_hit  = addr[ADDR_W-1];
   assign chan     = addr[CH_BITS:1];
   assign is_cnt   = addr[0];
   assign op       = ctl_op_e'(addr[2:0]);
   assign chan_acc = (rd_p || wr_p) && !ctl_hit;

   for (genvar k = 0; k < NUM_OPS; k++) begin : g_ops
      assign op_wr[k] = wr_p && ctl_hit && (op == ctl_op_e'(k));
      assign op_rd[k] = rd_p && ctl_hit && (op == ctl_op_e'(k));
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic hit;
      assign hit        = !ctl_hit && (chan == CH_BITS'(c));
      assign addr_we[c] = wr_p && hit && !is_cnt;
      assign cnt_we[c]  = wr_p && hit &&  is_cnt;
      assign addr_re[c] = rd_p && hit && !is_cnt;
      assign cnt_re[c]  = rd_p && hit &&  is_cnt;
   end

   dmaprog_byteptr u_ptr (
      .clk(clk), .rst(rst),
      .clr(op_wr[CTL_PTRCLR] || op_wr[CTL_MCLR]),
      .set(op_wr[CTL_PTRSET]),
      .flip(chan_acc),
      .ptr(byte_hi)
   );

   dmaprog_maskwidth #(
      .CH_BITS(CH_BITS), .NUM_CH(NUM_CH), .DATA_W(DATA_W), .WIDTH_SUPPORT(WIDTH_SUPPORT)
   ) u_mw (
      .clk(clk), .rst(rst),
      .mclr(op_wr[CTL_MCLR]),
      .wide_en(wide_en),
      .shared_wr(op_wr[CTL_SHARED]),
      .all_wr(op_wr[CTL_MASKALL]),
      .clr_all(op_wr[CTL_MASKCLR]),
      .din(din),
      .mask(mask_o),
      .width(width_o)
   );

   dmaprog_progregs #(
      .CH_BITS(CH_BITS), .NUM_CH(NUM_CH), .DATA_W(DATA_W), .MODE_W(MODE_W)
   ) u_prog (
      .clk(clk), .rst(rst),
      .mclr(op_wr[CTL_MCLR]),
      .cmd_wr(op_wr[CTL_CMD]),
      .mode_wr(op_wr[CTL_MODE]),
      .mode_rd(op_rd[CTL_MODE]),
      .idx_clr(op_rd[CTL_PTRCLR]),
      .din(din),
      .cmd(cmd_o),
      .modes(mode_o),
      .mode_rd_val(mode_rd_val)
   );

   assign width_rd      = wide_en ? width_o : '1;
   assign shared_rd_val = DATA_W'({width_rd, mask_o});

   always_comb begin
      rd_val = '0;
      if (op_rd[CTL_MODE])   rd_val = mode_rd_val;
      if (op_rd[CTL_SHARED]) rd_val = shared_rd_val;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)       dout <= '0;
      else if (rd_p) dout <= rd_val;
   end
endmodule

// File: rtl/dmaprog_regif_chk.sv
module dmaprog_regif_chk #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              ior_n,
   input logic              iow_n,
   input logic              hlda,
   input logic [ADDR_W-1:0] addr,
   input logic              byte_hi,
   input logic [NUM_CH-1:0] addr_we,
   input logic [NUM_CH-1:0] cnt_we,
   input logic [NUM_CH-1:0] addr_re,
   input logic [NUM_CH-1:0] cnt_re,
   input logic [NUM_CH-1:0] mask_o,
   input logic [NUM_CH-1:0] width_o,
   input logic [DATA_W-1:0] cmd_o
);
   localparam logic [ADDR_W-1:0] A_MASKALL = ADDR_W'((1 << (ADDR_W - 1)) + 3);
   localparam logic [ADDR_W-1:0] A_MCLR    = ADDR_W'((1 << (ADDR_W - 1)) + 6);

   logic wr_on, wr_prev, any_en, wr_new;

   assign wr_on  = !cs_n && !hlda && !iow_n && ior_n;
   assign any_en = |{addr_we, cnt_we, addr_re, cnt_re};
   assign wr_new = wr_on && !wr_prev;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) wr_prev <= 1'b0;
      else     wr_prev <= wr_on;
   end

   // R1
   unselected_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cs_n || hlda) |=> ($stable(mask_o) && $stable(width_o) && $stable(byte_hi) && $stable(cmd_o)));

   // R2
   held_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_on && wr_prev) |=> ($stable(mask_o) && $stable(byte_hi) && $stable(cmd_o)));

   // R3
   single_target_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({addr_we, cnt_we, addr_re, cnt_re}));

   // R4
   ptr_flip_chk: assert property (@(posedge clk) disable iff (rst)
      any_en |=> (byte_hi != $past(byte_hi)));

   // R6
   mclr_state_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_new && addr == A_MCLR) |=> ((&mask_o) && (&width_o) && !byte_hi && cmd_o == '0));

   // R10
   maskall_width_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_new && addr == A_MASKALL) |=> $stable(width_o));
endmodule

bind dmaprog_regif dmaprog_regif_chk #(
   .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/dmaprog_regif_tb_top.sv
`timescale 1ns/1ps
module dmaprog_regif_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1, hlda = 1'b0, wide_en = 1'b1;
   logic [3:0]  addr = 4'h0;
   logic [7:0]  din = 8'h00;
   logic [7:0]  dout, cmd_o;
   logic        byte_hi;
   logic [3:0]  addr_we, cnt_we, addr_re, cnt_re, mask_o, width_o;
   logic [23:0] mode_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // bench model
   logic [3:0] m_mask, m_width;
   logic       m_ptr;
   logic [7:0] m_cmd, m_dout;
   logic [5:0] m_mode [4];
   logic [1:0] m_idx;

   always #2.5 clk = ~clk;

   dmaprog_regif dut_i (
      .clk(clk), .rst(rst), .cs_n(cs_n), .ior_n(ior_n), .iow_n(iow_n), .hlda(hlda),
      .addr(addr), .din(din), .wide_en(wide_en), .dout(dout), .byte_hi(byte_hi),
      .addr_we(addr_we), .cnt_we(cnt_we), .addr_re(addr_re), .cnt_re(cnt_re),
      .mask_o(mask_o), .width_o(width_o), .cmd_o(cmd_o), .mode_o(mode_o)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input bit wr, input logic [3:0] a, input logic [7:0] d, input bit qual);
      if (!qual)  return "R1";
      if (!a[3])  return "R4";
      if (wr) begin
         case (a[2:0])
            3'd0, 3'd1: return "R12";
            3'd2:       return (wide_en && !d[3]) ? "R8" : "R9";
            3'd3, 3'd7: return "R10";
            3'd4, 3'd5: return "R5";
            default:    return "R6";
         endcase
      end
      if (a[2:0] == 3'd1 || a[2:0] == 3'd4) return "R13";
      return "R11";
   endfunction

   function automatic logic [15:0] exp_en(input bit wr, input logic [3:0] a, input bit qual);
      int off;
      if (!qual || a[3]) return 16'h0;
      off = wr ? (a[0] ? 8 : 12) : (a[0] ? 0 : 4);
      return 16'h1 << (off + int'(a[2:1]));
   endfunction

   task automatic mdl_reset();
      m_mask = 4'hF; m_width = 4'hF; m_ptr = 1'b0; m_cmd = 8'h00; m_idx = 2'd0; m_dout = 8'h00;
      for (int c = 0; c < 4; c++) m_mode[c] = 6'h00;
   endtask

   task automatic mdl_write(input logic [3:0] a, input logic [7:0] d);
      if (!a[3]) begin m_ptr = !m_ptr; return; end
      case (a[2:0])
         3'd0: m_cmd = d;
         3'd1: m_mode[d[1:0]] = d[7:2];
         3'd2: if (wide_en && !d[3]) m_width = d[7:4];
               else m_mask[d[1:0]] = d[2];
         3'd3: m_mask = d[3:0];
         3'd4: m_ptr = 1'b0;
         3'd5: m_ptr = 1'b1;
         3'd6: begin m_ptr = 1'b0; m_mask = 4'hF; m_width = 4'hF; m_cmd = 8'h00; m_idx = 2'd0; end
         default: m_mask = 4'h0;
      endcase
   endtask

   task automatic mdl_read(input logic [3:0] a);
      if (!a[3]) begin m_ptr = !m_ptr; m_dout = 8'h00; return; end
      case (a[2:0])
         3'd1: begin m_dout = {m_mode[m_idx], m_idx}; m_idx = m_idx + 2'd1; end
         3'd2: m_dout = {(wide_en ? m_width : 4'hF), m_mask};
         3'd4: begin m_dout = 8'h00; m_idx = 2'd0; end
         default: m_dout = 8'h00;
      endcase
   endtask

   task automatic compare_state(input string tag);
      chk(tag, "mask", 32'(mask_o), 32'(m_mask));
      chk(tag, "width", 32'(width_o), 32'(m_width));
      chk(tag, "byte_hi", 32'(byte_hi), 32'(m_ptr));
      chk(tag, "cmd", 32'(cmd_o), 32'(m_cmd));
      chk(tag, "dout", 32'(dout), 32'(m_dout));
      for (int c = 0; c < 4; c++) chk(tag, "mode", 32'(mode_o[c*6 +: 6]), 32'(m_mode[c]));
   endtask

   task automatic acc(input bit wr, input logic [3:0] a, input logic [7:0] d, input bit cs, input bit hl);
      bit    qual;
      string tg;
      qual = !cs && !hl;
      tg   = tag_of(wr, a, d, qual);
      @(negedge clk);
      cs_n = cs; hlda = hl; addr = a; din = d;
      if (wr) iow_n = 1'b0; else ior_n = 1'b0;
      #1;
      // R3: enables and byte select in the first strobe cycle
      chk(qual ? "R3" : "R1", "enables", 32'({addr_we, cnt_we, addr_re, cnt_re}), 32'(exp_en(wr, a, qual)));
      if (qual && !a[3]) chk("R3", "byte_hi", 32'(byte_hi), 32'(m_ptr));
      @(posedge clk);
      if (qual) begin
         if (wr) mdl_write(a, d); else mdl_read(a);
      end
      @(negedge clk);
      #1;
      // R2: held strobe raises nothing
      chk("R2", "held enables", 32'({addr_we, cnt_we, addr_re, cnt_re}), 32'h0);
      @(negedge clk);
      iow_n = 1'b1; ior_n = 1'b1; cs_n = 1'b1; hlda = 1'b0;
      #1;
      compare_state(tg);
   endtask

   initial begin
      mdl_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      compare_state("R7");

      wide_en = 1'b1;
      acc(1, 4'hA, 8'h50, 0, 0);   // R8 width load
      acc(1, 4'hA, 8'h0A, 0, 0);   // R9 clear mask ch2
      acc(0, 4'hA, 8'h00, 0, 0);   // R11 expect 5B
      chk("R11", "dout shared", 32'(dout), 32'h5B);
      @(negedge clk); wide_en = 1'b0;
      acc(1, 4'hA, 8'h01, 0, 0);   // R9 bit3=0 but narrow mode: clear ch1
      acc(0, 4'hA, 8'h00, 0, 0);   // R11 expect F9
      chk("R11", "dout narrow", 32'(dout), 32'hF9);
      acc(1, 4'hB, 8'hF6, 0, 0);   // R10
      acc(1, 4'hF, 8'hFF, 0, 0);   // R10 clear all
      chk("R10", "mask after clear", 32'(mask_o), 32'h0);
      acc(1, 4'h2, 8'h11, 0, 0);   // R4
      acc(0, 4'h3, 8'h00, 0, 0);   // R4
      acc(1, 4'hD, 8'h00, 0, 0);   // R5 set
      chk("R5", "ptr set", 32'(byte_hi), 32'h1);
      acc(1, 4'hC, 8'hFF, 0, 0);   // R5 clear
      chk("R5", "ptr clear", 32'(byte_hi), 32'h0);
      acc(1, 4'h8, 8'hA5, 0, 0);   // R12
      acc(1, 4'h9, 8'hB7, 0, 0);   // R12 ch3 mode 2D
      for (int i = 0; i < 4; i++) acc(0, 4'h9, 8'h00, 0, 0); // R13
      chk("R13", "mode ch3 read", 32'(dout), 32'hB7);
      acc(0, 4'h9, 8'h00, 0, 0);
      acc(0, 4'hC, 8'h00, 0, 0);   // R13 restart
      acc(0, 4'h9, 8'h00, 0, 0);
      chk("R13", "restart index", 32'(dout), 32'h00);
      acc(1, 4'hE, 8'h00, 1, 0);   // R1 no cs
      acc(1, 4'hE, 8'h00, 0, 1);   // R1 hlda
      acc(0, 4'h4, 8'h00, 1, 0);   // R1
      acc(1, 4'hE, 8'h00, 0, 0);   // R6
      chk("R6", "mask after mclr", 32'(mask_o), 32'hF);

      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         logic [3:0] a;
         logic [7:0] d;
         bit wr, cs, hl;
         a  = 4'($urandom_range(0, 15));
         d  = 8'($urandom_range(0, 255));
         wr = 1'($urandom_range(0, 1));
         cs = ($urandom_range(0, 9) == 0);
         hl = ($urandom_range(0, 9) == 0);
         if (a == 4'hE && $urandom_range(0, 3) != 0) a = 4'hA;
         if ($urandom_range(0, 15) == 0) begin
            @(negedge clk);
            wide_en = !wide_en;
         end
         acc(wr, a, d, cs, hl);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule